// File: doc/BRIEF.md
# Interrupt Concentrator with AXI4-Lite Control

This block collects a parameterised set of peripheral interrupt lines, up to 32, and folds them into one level-high request for a processor. Each line is tracked by a pending bit. Software reads the pending bits, selects which lines may raise the request, and clears serviced lines through an AXI4-Lite slave port. A two-bit master control word arms the output and chooses between a software test mode and normal hardware operation.

Each input has a fixed detection mode, set by the `EDGE_MASK` parameter. An edge-mode line sets its pending bit on a low-to-high transition. A level-mode line keeps its pending bit set while the line is high. While hardware operation is off, the inputs are ignored and software may set pending bits by writing the status word. This lets the full path to the processor be tested without a peripheral. A lookup word returns the lowest-numbered line that is both pending and enabled.

Top module: `intc_top`

## Requirements
- R1: After reset the status, enable and master control words read 0, the lowest-pending word reads 0xFFFFFFFF, and `irq_o` is low.
- R2: While master bit 1 (hardware enable) is 0, a write to the status word (offset 0x00) ORs its data into the pending bits, and the input lines set no pending bit.
- R3: `irq_o` is high exactly when master bit 0 (output enable) is 1 and at least one bit is both pending and enabled (enable word at offset 0x08). It stays high until that bit is acknowledged.
- R4: Writing ones to the acknowledge word (offset 0x0C) clears those pending bits and leaves the others unchanged. The acknowledge word always reads 0.
- R5: With hardware enable set, an edge-mode line (`EDGE_MASK` bit 1) sets its pending bit on a rising edge only. A line held high after its bit is acknowledged does not set the bit again.
- R6: With hardware enable set, a level-mode line (`EDGE_MASK` bit 0) holds its pending bit set while it is high. An acknowledge while the line is high leaves the bit set. An acknowledge after the line falls clears it.
- R7: While hardware enable is 1, writes to the status word do not change the pending bits.
- R8: Offset 0x04 reads the bitwise AND of the pending and enable words. Writes to offset 0x04 are ignored.
- R9: Offset 0x18 reads the index of the lowest-numbered bit that is pending and enabled, or 0xFFFFFFFF when there is none.
- R10: The slave accepts write address and write data in either order and keeps one transaction outstanding per direction. It answers OKAY (00) at offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C. It answers SLVERR (10) with read data 0 at offsets 0x10 and 0x14, and a write to those offsets has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Active-low reset |
| irq_src_i | input | N_IRQ | Peripheral interrupt lines |
| irq_o | output | 1 | Level-high interrupt request |
| s_awaddr_i | input | 5 | Write address (byte) |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | 5 | Read address (byte) |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |

## Verification
The bench builds the block with `N_IRQ = 8` and `EDGE_MASK = 8'h0F`, so lines 0 to 3 are edge mode and lines 4 to 7 are level mode. Both detection modes therefore run in one build. Acknowledging a line while it is still held high shows the opposite outcomes for the two modes. The narrow width also puts the "none pending" value of the lookup word and the zero-extended upper bits of every word within reach of directed tests.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    W_STS  = 3'd0,
    W_IPR  = 3'd1,
    W_IER  = 3'd2,
    W_ACK  = 3'd3,
    W_RSV4 = 3'd4,
    W_RSV5 = 3'd5,
    W_PNUM = 3'd6,
    W_MER  = 3'd7
  } word_e;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;

  function automatic logic word_mapped(word_e w);
    return (w != W_RSV4) && (w != W_RSV5);
  endfunction
endpackage

// File: rtl/intc_axil_slave.sv
module intc_axil_slave
  import intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              wr_en_o,
  output word_e             wr_word_o,
  output logic [DATA_W-1:0] wr_data_o,
  output word_e             rd_word_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic              aw_q, w_q, fire;
  word_e             aw_word_q;
  logic [DATA_W-1:0] w_data_q;
  logic              unused_lsb;

  assign unused_lsb = ^{awaddr_i[1:0], araddr_i[1:0]};
  assign awready_o  = !aw_q;
  assign wready_o   = !w_q;
  assign arready_o  = !rvalid_o;
  // one write in flight: execute only once the previous response is taken
  assign fire       = aw_q && w_q && !bvalid_o;
  assign wr_en_o    = fire && word_mapped(aw_word_q);
  assign wr_word_o  = aw_word_q;
  assign wr_data_o  = w_data_q;
  assign rd_word_o  = word_e'(araddr_i[4:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_q      <= 1'b0;
      w_q       <= 1'b0;
      aw_word_q <= W_STS;
      w_data_q  <= '0;
      bvalid_o  <= 1'b0;
      bresp_o   <= RESP_OKAY;
    end else begin
      if (awvalid_i && !aw_q) begin
        aw_q      <= 1'b1;
        aw_word_q <= word_e'(awaddr_i[4:2]);
      end
      if (wvalid_i && !w_q) begin
        w_q      <= 1'b1;
        w_data_q <= wdata_i;
      end
      if (fire) begin
        aw_q     <= 1'b0;
        w_q      <= 1'b0;
        bvalid_o <= 1'b1;
        bresp_o  <= word_mapped(aw_word_q) ? RESP_OKAY : RESP_SLVERR;
      end else if (bvalid_o && bready_i) begin
        bvalid_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      rresp_o  <= RESP_OKAY;
    end else if (arvalid_i && !rvalid_o) begin
      rvalid_o <= 1'b1;
      rdata_o  <= word_mapped(rd_word_o) ? rd_data_i : '0;
      rresp_o  <= word_mapped(rd_word_o) ? RESP_OKAY : RESP_SLVERR;
    end else if (rvalid_o && rready_i) begin
      rvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_pend_core.sv
module intc_pend_core
  import intc_pkg::*;
#(
  parameter int unsigned           N_IRQ     = 32,
  parameter logic [N_IRQ-1:0]      EDGE_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  src_i,
  input  logic              wr_en_i,
  input  word_e             wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_IRQ-1:0]  pend_o,
  output logic [N_IRQ-1:0]  en_o,
  output logic              out_en_o,
  output logic              hw_en_o
);
  logic [N_IRQ-1:0] src_q, det, hw_set, sw_set, ack;
  logic             unused_data;

  assign unused_data = ^wr_data_i;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_det
    if (EDGE_MASK[i]) begin : g_edge
      assign det[i] = src_i[i] && !src_q[i];
    end else begin : g_level
      assign det[i] = src_i[i];
    end
  end

  assign hw_set = hw_en_o ? det : '0;
  assign sw_set = (wr_en_i && wr_word_i == W_STS && !hw_en_o) ? wr_data_i[N_IRQ-1:0] : '0;
  assign ack    = (wr_en_i && wr_word_i == W_ACK) ? wr_data_i[N_IRQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      pend_o   <= '0;
      en_o     <= '0;
      out_en_o <= 1'b0;
      hw_en_o  <= 1'b0;
    end else begin
      src_q  <= src_i;
      // a new detection wins over a same-cycle acknowledge
      pend_o <= (pend_o & ~ack) | hw_set | sw_set;
      if (wr_en_i && wr_word_i == W_IER) en_o <= wr_data_i[N_IRQ-1:0];
      if (wr_en_i && wr_word_i == W_MER) begin
        out_en_o <= wr_data_i[0];
        hw_en_o  <= wr_data_i[1];
      end
    end
  end
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int unsigned N     = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int unsigned      N_IRQ     = 32,
  parameter logic [N_IRQ-1:0] EDGE_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_src_i,
  output logic              irq_o,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i
);
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic              wr_en;
  word_e             wr_word, rd_word;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [N_IRQ-1:0]  pend_w, en_w, ipr_w;
  logic              out_en_w, hw_en_w, found_w;
  logic [IDX_W-1:0]  idx_w;

  intc_axil_slave u_bus (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .wr_en_o(wr_en), .wr_word_o(wr_word), .wr_data_o(wr_data),
    .rd_word_o(rd_word), .rd_data_i(rd_data)
  );

  intc_pend_core #(.N_IRQ(N_IRQ), .EDGE_MASK(EDGE_MASK)) u_core (
    .clk_i, .rst_ni, .src_i(irq_src_i),
    .wr_en_i(wr_en), .wr_word_i(wr_word), .wr_data_i(wr_data),
    .pend_o(pend_w), .en_o(en_w), .out_en_o(out_en_w), .hw_en_o(hw_en_w)
  );

  assign ipr_w = pend_w & en_w;

  intc_lowest #(.N(N_IRQ)) u_low (.vec_i(ipr_w), .found_o(found_w), .idx_o(idx_w));

  assign irq_o = out_en_w && (|ipr_w);

  always_comb begin
    unique case (rd_word)
      W_STS:   rd_data = DATA_W'(pend_w);
      W_IPR:   rd_data = DATA_W'(ipr_w);
      W_IER:   rd_data = DATA_W'(en_w);
      W_PNUM:  rd_data = found_w ? DATA_W'(idx_w) : '1;
      W_MER:   rd_data = DATA_W'({hw_en_w, out_en_w});
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned      N_IRQ     = 32,
  parameter logic [N_IRQ-1:0] EDGE_MASK = '1,
  localparam int unsigned     IDX_W     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             bvalid,
  input logic             bready,
  input logic             rvalid,
  input logic             rready,
  input logic [N_IRQ-1:0] src,
  input logic [N_IRQ-1:0] pend,
  input logic [N_IRQ-1:0] en,
  input logic             out_en,
  input logic             hw_en,
  input logic             found,
  input logic [IDX_W-1:0] idx
);
  localparam logic [N_IRQ-1:0] LVL = ~EDGE_MASK;

  p_bvalid_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid && !bready) |=> bvalid);

  p_rvalid_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid && !rready) |=> rvalid);

  p_irq_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en |-> !irq_o);

  p_level_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_en |=> ((pend & $past(src & LVL)) == $past(src & LVL)));

  p_lowest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (((pend & en) >> idx) & 1) == 1 && ((pend & en) & ~({N_IRQ{1'b1}} << idx)) == '0);

  p_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found |-> (pend & en) == '0);
endmodule

bind intc_top intc_chk #(.N_IRQ(N_IRQ), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o),
  .bvalid(s_bvalid_o), .bready(s_bready_i), .rvalid(s_rvalid_o), .rready(s_rready_i),
  .src(irq_src_i), .pend(pend_w), .en(en_w), .out_en(out_en_w), .hw_en(hw_en_w),
  .found(found_w), .idx(idx_w)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic irq;
  logic [4:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1;
  logic [31:0] wdata = '0, rdata;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  int vectors = 0, miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top #(.N_IRQ(N), .EDGE_MASK(8'h0F)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .irq_o(irq),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_b(output logic [1:0] resp);
    while (!bvalid) begin @(posedge clk); #1; end
    resp = bresp;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output logic [1:0] resp);
    @(negedge clk); awaddr = a; awvalid = 1; wdata = d; wvalid = 1;
    @(posedge clk); #1; awvalid = 0; wvalid = 0;
    wait_b(resp);
  endtask

  task automatic wr_data_first(input logic [4:0] a, input logic [31:0] d, output logic [1:0] resp);
    @(negedge clk); wdata = d; wvalid = 1;
    @(posedge clk); #1; wvalid = 0;
    @(negedge clk); awaddr = a; awvalid = 1;
    @(posedge clk); #1; awvalid = 0;
    wait_b(resp);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk); araddr = a; arvalid = 1;
    @(posedge clk); #1; arvalid = 0;
    while (!rvalid) begin @(posedge clk); #1; end
    d = rdata; resp = rresp;
    @(posedge clk); #1;
  endtask

  task automatic w(input logic [4:0] a, input logic [31:0] d);
    logic [1:0] r;
    wr(a, d, r);
  endtask

  task automatic expect_rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d; logic [1:0] r;
    rd(a, d, r);
    chk(tag, d, exp);
  endtask

  task automatic set_src(input logic [N-1:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    expect_rd("R1 status", 5'h00, 32'h0);
    expect_rd("R1 enable", 5'h08, 32'h0);
    expect_rd("R1 master", 5'h1C, 32'h0);
    expect_rd("R1 lowest", 5'h18, 32'hFFFF_FFFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_sw_inject;
    w(5'h08, 32'h04);
    w(5'h1C, 32'h1);
    set_src(8'h20);
    expect_rd("R2 input ignored", 5'h00, 32'h0);
    set_src(8'h00);
    w(5'h00, 32'h04);
    expect_rd("R2 sw set", 5'h00, 32'h04);
    chk("R3 irq high", {31'h0, irq}, 32'h1);
    w(5'h00, 32'h01);
    expect_rd("R2 sw or", 5'h00, 32'h05);
    expect_rd("R8 ipr", 5'h04, 32'h04);
    expect_rd("R9 lowest", 5'h18, 32'h2);
    w(5'h1C, 32'h0);
    chk("R3 gated", {31'h0, irq}, 32'h0);
    w(5'h1C, 32'h1);
    chk("R3 rearm", {31'h0, irq}, 32'h1);
    expect_rd("R4 ack reads 0", 5'h0C, 32'h0);
    w(5'h0C, 32'h04);
    expect_rd("R4 ack partial", 5'h00, 32'h01);
    chk("R3 irq low after ack", {31'h0, irq}, 32'h0);
    w(5'h0C, 32'h01);
    expect_rd("R4 ack rest", 5'h00, 32'h0);
  endtask

  task automatic t_edge;
    w(5'h1C, 32'h3);
    w(5'h08, 32'hFF);
    set_src(8'h02);
    expect_rd("R5 edge latch", 5'h00, 32'h02);
    chk("R3 irq from edge", {31'h0, irq}, 32'h1);
    w(5'h0C, 32'h02);
    expect_rd("R5 held high no repend", 5'h00, 32'h0);
    chk("R5 irq low", {31'h0, irq}, 32'h0);
    w(5'h00, 32'h80);
    expect_rd("R7 sw write blocked", 5'h00, 32'h0);
    set_src(8'h00);
    set_src(8'h02);
    expect_rd("R5 second edge", 5'h00, 32'h02);
    w(5'h0C, 32'h02);
    set_src(8'h00);
  endtask

  task automatic t_level;
    set_src(8'h40);
    expect_rd("R6 level pend", 5'h00, 32'h40);
    w(5'h0C, 32'h40);
    expect_rd("R6 ack while high", 5'h00, 32'h40);
    set_src(8'h00);
    w(5'h0C, 32'h40);
    expect_rd("R6 ack after low", 5'h00, 32'h0);
  endtask

  task automatic t_lowest;
    w(5'h08, 32'h20);
    set_src(8'h28);
    expect_rd("R8 ipr masked", 5'h04, 32'h20);
    expect_rd("R9 masked lowest", 5'h18, 32'h5);
    w(5'h04, 32'hFF);
    expect_rd("R8 ipr read-only", 5'h04, 32'h20);
    w(5'h08, 32'hFF);
    expect_rd("R9 lowest", 5'h18, 32'h3);
    w(5'h0C, 32'h08);
    expect_rd("R9 next lowest", 5'h18, 32'h5);
    set_src(8'h00);
    w(5'h0C, 32'h20);
    expect_rd("R9 none", 5'h18, 32'hFFFF_FFFF);
  endtask

  task automatic t_bus;
    logic [31:0] d; logic [1:0] r;
    rd(5'h10, d, r);
    chk("R10 unmapped rresp", {30'h0, r}, 32'h2);
    chk("R10 unmapped rdata", d, 32'h0);
    wr(5'h14, 32'h0, r);
    chk("R10 unmapped bresp", {30'h0, r}, 32'h2);
    expect_rd("R10 no effect", 5'h08, 32'hFF);
    wr_data_first(5'h08, 32'h33, r);
    chk("R10 data-first bresp", {30'h0, r}, 32'h0);
    expect_rd("R10 data-first effect", 5'h08, 32'h33);
    rd(5'h1C, d, r);
    chk("R10 mapped rresp", {30'h0, r}, 32'h0);
    chk("R10 master readback", d, 32'h3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_sw_inject();
    t_edge();
    t_level();
    t_lowest();
    t_bus();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule